// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog that runs from a slow reference clock. The reference first passes through a fixed power-of-two divider (divide-by-512 by default). A second power-of-two divider follows it, chosen by a 3-bit prescale code. The output of the second divider advances a watchdog counter, 8 bits wide by default. Software has to service the watchdog before that counter wraps. If it does not, the block either raises a sticky wake interrupt or drives a chip reset request, depending on a mode bit.

Software uses a small write port with three addresses. Address 0 is control: bit 0 enables the watchdog, bit 1 selects the overflow action (1 = reset request, 0 = interrupt), and bits 4:2 hold the prescale code. Address 1 is the service key. Address 2 clears the interrupt: writing a 1 to bit 0 clears it. With a 10 MHz reference and the default sizes, the timeout ranges from about 13.1 ms at the fastest setting to about 839 ms at the slowest.

Top module: `wdog_prescaled`

## Requirements
- R1: After reset the watchdog is disabled, the control fields are zero, and both `irq` and `rst_req` are low.
- R2: In interrupt mode, `irq` rises exactly 2^CNT_W × 2^FIX_LOG2 × D clock edges after the edge that accepts the enabling control write. D depends on the prescale code: codes 0 and 1 give D = 1, and any code k of 2 or more gives D = 2^(k-1).
- R3: In interrupt mode the counter wraps to zero on overflow and keeps counting, so the next overflow comes one full timeout later.
- R4: Writing 0x55 to the key address and then, as the very next key write, 0xAA clears the watchdog counter and every prescaler stage. A full timeout then restarts from the edge that accepts the 0xAA write.
- R5: A key sequence in the wrong order, or one with any other key value between 0x55 and 0xAA, clears nothing, and the original timeout stands.
- R6: The interrupt flag stays set until a write to address 2 with bit 0 set. A write to address 2 with bit 0 clear leaves the flag unchanged.
- R7: In reset mode, overflow drives `rst_req` high for exactly RST_CYCLES clock cycles. The pulse starts at the edge where the timeout expires.
- R8: When the reset pulse ends, all watchdog state returns to its reset defaults. The watchdog is then disabled, the interrupt flag is clear, and no further events occur.
- R9: While disabled, the counter and all prescaler stages are held at zero and no event is produced. Enabling again starts a full timeout.
- R10: A change to the prescale code while the watchdog runs keeps the partial prescaler count. The new divisor applies from the next prescaled tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 key, 2 interrupt clear |
| wr_data | input | 8 | Register write data |
| irq | output | 1 | Sticky wake interrupt flag |
| rst_req | output | 1 | Chip reset request pulse |

## Verification
The hardest case to reach is a prescale change in the middle of a period, because the preserved partial count can only be seen through when the overflow arrives. The bench starts at divide-by-4 and switches to divide-by-8 on the exact edge of the second fixed-stage tick. If the partial count is kept, overflow lands at the pure divide-by-8 timeout. If it is lost, overflow comes later, and the bench detects that. Sizes are reduced for the bench: a /4 fixed stage, a 5-bit counter and a 16-cycle reset pulse. With these sizes every prescale code can be swept through full timeouts and wraps.

// File: rtl/wdog_prescaled.sv
module wdog_prescaled #(
  parameter int FIX_LOG2   = 9,
  parameter int CNT_W      = 8,
  parameter int RST_CYCLES = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       irq,
  output logic       rst_req
);
  localparam int PRE_W = 6;
  localparam int RC_W  = $clog2(RST_CYCLES + 1);
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;
  localparam logic [PRE_W-1:0] PRE_ONE = 1;

  logic                en, mode_rst, armed;
  logic [2:0]          ps;
  logic [FIX_LOG2-1:0] fix_cnt;
  logic [PRE_W-1:0]    pre_cnt, pre_mask;
  logic [CNT_W-1:0]    wd_cnt;
  logic [RC_W-1:0]     rst_cnt;

  wire run      = en && !rst_req;
  wire wr_ok    = wr_en && !rst_req;
  wire ctl_wr   = wr_ok && wr_addr == 2'd0;
  wire key_wr   = wr_ok && wr_addr == 2'd1;
  wire clr_wr   = wr_ok && wr_addr == 2'd2 && wr_data[0];
  wire service  = key_wr && armed && wr_data == KEY_FIRE;
  wire last_rst = rst_req && rst_cnt == RC_W'(RST_CYCLES - 1);

  always_comb
    pre_mask = (ps < 3'd2) ? '0 : (PRE_ONE << (ps - 3'd1)) - PRE_ONE;

  wire fix_tick = run && (&fix_cnt);
  wire pre_tick = fix_tick && ((pre_cnt & pre_mask) == pre_mask);
  wire ovf      = pre_tick && (&wd_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n || last_rst || !run || service) begin
      fix_cnt <= '0;
      pre_cnt <= '0;
      wd_cnt  <= '0;
    end else begin
      fix_cnt <= fix_cnt + 1'b1;
      if (fix_tick) pre_cnt <= pre_cnt + 1'b1;
      if (pre_tick) wd_cnt  <= wd_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || last_rst) begin
      en <= 1'b0; mode_rst <= 1'b0; ps <= 3'd0; armed <= 1'b0;
    end else begin
      if (ctl_wr) {ps, mode_rst, en} <= wr_data[4:0];
      if (key_wr) armed <= (wr_data == KEY_ARM);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || last_rst)        irq <= 1'b0;
    else if (ovf && !mode_rst)     irq <= 1'b1;
    else if (clr_wr)               irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      rst_cnt <= '0;
    end else if (rst_req) begin
      if (last_rst) rst_req <= 1'b0;
      rst_cnt <= rst_cnt + 1'b1;
    end else if (ovf && mode_rst) begin
      rst_req <= 1'b1;
      rst_cnt <= '0;
    end
  end

  // R7
  rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> $past(rst_cnt) == RC_W'(RST_CYCLES - 1));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !rst_req) |=> !$rose(irq) && !$rose(rst_req));

  // R2
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !$past(mode_rst) && $past(wd_cnt) == {CNT_W{1'b1}});

  // R6
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr && !rst_req) |=> irq);

  // R4
  service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && armed && wr_data == KEY_FIRE) |=> wd_cnt == '0);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (wd_cnt == $past(wd_cnt) || wd_cnt == $past(wd_cnt) + 1'b1 || wd_cnt == '0));
endmodule

// File: tb/wdog_prescaled_bench.sv
module wdog_prescaled_bench;
  localparam int FL = 2;
  localparam int W  = 5;
  localparam int RC = 16;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic irq, rst_req;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  wdog_prescaled #(.FIX_LOG2(FL), .CNT_W(W), .RST_CYCLES(RC)) u_wdog_prescaled (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq(irq), .rst_req(rst_req));

  function automatic int tmo(input int code);
    return (1 << W) * (1 << FL) * ((code < 2) ? 1 : (1 << (code - 1)));
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    waitn(3);
    rst_n = 1'b1;
    chk("R1 irq", irq, 1'b0);
    chk("R1 rst_req", rst_req, 1'b0);
    waitn(300);
    chk("R9 idle irq", irq, 1'b0);
    chk("R9 idle rst_req", rst_req, 1'b0);

    for (int code = 0; code < 8; code++) begin
      n = tmo(code);
      wr(2'd0, {3'b000, 3'(code), 1'b0, 1'b1});
      waitn(n - 1);
      chk("R2 before timeout", irq, 1'b0);
      waitn(1);
      chk("R2 at timeout", irq, 1'b1);
      wr(2'd2, 8'hFE);
      chk("R6 zero write keeps flag", irq, 1'b1);
      wr(2'd2, 8'h01);
      chk("R6 clear", irq, 1'b0);
      waitn(n - 3);
      chk("R3 before wrap timeout", irq, 1'b0);
      waitn(1);
      chk("R3 wrap timeout", irq, 1'b1);
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h01);
    end

    n = tmo(0);
    wr(2'd0, 8'h01);
    waitn(60);
    wr(2'd0, 8'h00);
    waitn(500);
    chk("R9 disabled no irq", irq, 1'b0);
    wr(2'd0, 8'h01);
    waitn(n - 1);
    chk("R9 restart before", irq, 1'b0);
    waitn(1);
    chk("R9 restart full timeout", irq, 1'b1);
    wr(2'd0, 8'h00); wr(2'd2, 8'h01);

    wr(2'd0, {3'b000, 3'd1, 1'b0, 1'b1});
    waitn(99);
    wr(2'd1, 8'h55);
    wr(2'd1, 8'hAA);
    waitn(n - 1);
    chk("R4 serviced before", irq, 1'b0);
    waitn(1);
    chk("R4 serviced timeout", irq, 1'b1);
    wr(2'd0, 8'h00); wr(2'd2, 8'h01);

    wr(2'd0, 8'h01);
    wr(2'd1, 8'hAA);
    wr(2'd1, 8'h55);
    wr(2'd1, 8'h12);
    wr(2'd1, 8'hAA);
    waitn(n - 5);
    chk("R5 bad key before", irq, 1'b0);
    waitn(1);
    chk("R5 bad key original timeout", irq, 1'b1);
    wr(2'd0, 8'h00); wr(2'd2, 8'h01);

    wr(2'd0, {3'b000, 3'd3, 1'b0, 1'b1});
    waitn(2 * (1 << FL) - 1);
    wr(2'd0, {3'b000, 3'd4, 1'b0, 1'b1});
    n = tmo(4);
    waitn(n - 2 * (1 << FL) - 1);
    chk("R10 before", irq, 1'b0);
    waitn(1);
    chk("R10 partial kept", irq, 1'b1);
    wr(2'd0, 8'h00);

    n = tmo(0);
    wr(2'd0, 8'h03);
    waitn(n - 1);
    chk("R7 before", rst_req, 1'b0);
    waitn(1);
    chk("R7 start", rst_req, 1'b1);
    for (int i = 1; i < RC; i++) begin
      waitn(1);
      chk("R7 held", rst_req, 1'b1);
    end
    chk("R8 flag during pulse", irq, 1'b1);
    waitn(1);
    chk("R7 end", rst_req, 1'b0);
    chk("R8 flag cleared", irq, 1'b0);
    waitn(3 * n);
    chk("R8 disabled rst_req", rst_req, 1'b0);
    chk("R8 disabled irq", irq, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule